// File: doc/BRIEF.md
# Audio Port FIFO Request and Interrupt Controller

This block holds the control and status register for a serial audio port that has one receive FIFO and one secondary transmit FIFO. It owns the software reset that keeps the audio datapath held until software releases it. It catches receive-overflow and transmit-underrun pulses in sticky flags, and each flag has its own interrupt enable. It drives the external DMA request that refills the transmit FIFO.

Software reaches the block through one 32-bit register with a write strobe and a combinational read. The FIFOs report their empty and full levels and their error pulses on plain inputs. A DMA engine answers each request with a one-cycle acknowledge. Pausing the DMA lets the transfer in flight finish before requests stop. Clearing the active bit withdraws the request at once, without waiting for an acknowledge.

Top module: `aud_fifo_ctl`

## Requirements
- R1: After hardware reset, every register bit reads 0, `aud_rst_n` is 0, and `dma_req` and `irq` are 0.
- R2: Bit 0 is the run bit. It is read/write, and `aud_rst_n` follows its registered value. A value of 0 holds the audio datapath in reset.
- R3: Bit 8 is the receive-overflow flag. A cycle with `rx_ovf_evt` high sets it. It stays set until a write with bit 8 equal to 1 clears it. A write with bit 8 equal to 0 leaves it unchanged.
- R4: Bit 9 is the transmit-underrun flag. `tx_und_evt` sets it. It is cleared and kept in the same way as the R3 flag, using bit 9.
- R5: When an event arrives in the same cycle as a write-1 clear of its flag, the flag stays set.
- R6: `irq` is high exactly when (bit 8 and enable bit 1 are both set) or (bit 9 and enable bit 2 are both set).
- R7: Bit 12 reads `tx_empty` and bit 13 reads `tx_full` in the same cycle. Writes to these bits have no effect.
- R8: Bits 7:5, 11:10 and 31:14 read as 0 whatever value is written.
- R9: Bit 3 is the DMA active bit and bit 4 is the DMA pause bit. With active=1, pause=0 and no request in flight, `dma_req` rises one cycle after a cycle in which `tx_full` is low. It then stays high until the cycle after `dma_ack` is sampled high.
- R10: Setting pause while a request is in flight keeps `dma_req` high until that request is acknowledged. After the acknowledge, no new request starts while pause is set.
- R11: Writing active=0 drops `dma_req` in the cycle after the write, with no acknowledge. The request in flight is abandoned.
- R12: No new request starts while `tx_full` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| rx_ovf_evt | input | 1 | Receive FIFO overflow pulse |
| tx_und_evt | input | 1 | Transmit FIFO underrun pulse |
| tx_empty | input | 1 | Transmit FIFO has no data ready |
| tx_full | input | 1 | Transmit FIFO is full |
| dma_req | output | 1 | External DMA request for the transmit FIFO |
| dma_ack | input | 1 | DMA transfer complete acknowledge |
| irq | output | 1 | Combined masked interrupt |
| aud_rst_n | output | 1 | Software reset to the audio datapath, active low |

## Verification
The bench targets a clear that lands in the same cycle as a new event. A design that gave priority to the write would lose that event, and the R5 flag check would read 0. It then sets pause in the middle of a transfer: a design that stops at once would drop the request before the acknowledge, and one that ignores pause would raise a new request after it. It also clears active while a request is pending, to catch a design that waits for the acknowledge. Last, it holds the FIFO full, so a request raised regardless of level shows up on `dma_req`. A long random run of writes, events, acknowledges and FIFO levels compares every output each cycle with a reference model.

// File: rtl/aud_fifo_ctl_pkg.sv
package aud_fifo_ctl_pkg;
  localparam int REG_W    = 32;
  localparam int CTL_W    = 5;
  localparam int NFLAG    = 2;
  localparam int FLAG_LSB = 8;
  localparam int STAT_LSB = 12;
  localparam int B_RUN    = 0;
  localparam int B_IE_LSB = 1;
  localparam int B_ACT    = 3;
  localparam int B_PAUSE  = 4;

  typedef struct packed {
    logic             pause;
    logic             act;
    logic [NFLAG-1:0] ie;
    logic             run;
  } ctl_t;
endpackage

// File: rtl/aud_fifo_ctl_regs.sv
module aud_fifo_ctl_regs
  import aud_fifo_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_i) ctl_d = ctl_t'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (ctl_q.run == $past(wdata_i[B_RUN])));
  p_hold_nowr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctl_q));
endmodule

// File: rtl/aud_fifo_ctl_flags.sv
module aud_fifo_ctl_flags
  import aud_fifo_ctl_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb flag_d[i] = evt_i[i] | (flag_q[i] & ~clr_i[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flag_q[i]);
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ie_i);

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q != '0));
endmodule

// File: rtl/aud_fifo_ctl_dma.sv
module aud_fifo_ctl_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic pause_i,
  input  logic full_i,
  input  logic ack_i,
  output logic req_o
);
  logic busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (!act_i)      busy_d = 1'b0;
    else if (busy_q) busy_d = !ack_i;
    else             busy_d = !pause_i && !full_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign req_o = busy_q & act_i;

  p_hold_to_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o || !act_i));
  p_no_start_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && full_i) |=> !req_o);
  p_no_start_paused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && pause_i) |=> !req_o);
  p_drop_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> !req_o);
endmodule

// File: rtl/aud_fifo_ctl.sv
module aud_fifo_ctl
  import aud_fifo_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             rx_ovf_evt,
  input  logic             tx_und_evt,
  input  logic             tx_empty,
  input  logic             tx_full,
  output logic             dma_req,
  input  logic             dma_ack,
  output logic             irq,
  output logic             aud_rst_n
);
  logic       rst_s1_q, rst_s2_q;
  ctl_t       ctl;
  logic [NFLAG-1:0] flags, clr;
  logic       unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s2_q, rst_s1_q} <= 2'b00;
    else        {rst_s2_q, rst_s1_q} <= {rst_s1_q, 1'b1};
  end

  assign unused_wbits = ^{reg_wdata[REG_W-1:FLAG_LSB+NFLAG], reg_wdata[FLAG_LSB-1:CTL_W]};

  aud_fifo_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .wr_i    (reg_wr),
    .wdata_i (reg_wdata[CTL_W-1:0]),
    .ctl_o   (ctl)
  );

  assign clr = reg_wr ? reg_wdata[FLAG_LSB +: NFLAG] : '0;

  aud_fifo_ctl_flags #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .evt_i  ({tx_und_evt, rx_ovf_evt}),
    .clr_i  (clr),
    .ie_i   (ctl.ie),
    .flag_o (flags),
    .irq_o  (irq)
  );

  aud_fifo_ctl_dma u_dma (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .act_i   (ctl.act),
    .pause_i (ctl.pause),
    .full_i  (tx_full),
    .ack_i   (dma_ack),
    .req_o   (dma_req)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[CTL_W-1:0]           = ctl;
    reg_rdata[FLAG_LSB +: NFLAG]   = flags;
    reg_rdata[STAT_LSB]            = tx_empty;
    reg_rdata[STAT_LSB+1]          = tx_full;
  end

  assign aud_rst_n = ctl.run;

  p_kill_on_inactive_r11: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (reg_wr && !reg_wdata[B_ACT]) |=> !dma_req);
  p_event_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (rx_ovf_evt && reg_wr && reg_wdata[FLAG_LSB]) |=> reg_rdata[FLAG_LSB]);
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (reg_rdata[REG_W-1:STAT_LSB+2] == '0) && (reg_rdata[FLAG_LSB-1:CTL_W] == '0));
endmodule

// File: tb/aud_fifo_ctl_tb_top.sv
module aud_fifo_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, rx_ovf_evt, tx_und_evt, tx_empty, tx_full, dma_ack;
  logic [31:0] reg_wdata, reg_rdata;
  logic        dma_req, irq, aud_rst_n;

  int n_chk = 0;
  int n_err = 0;

  logic m_run, m_ier, m_iet, m_act, m_pause, m_rxf, m_txf, m_busy;

  always #2.5 clk = ~clk;

  aud_fifo_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_ovf_evt(rx_ovf_evt), .tx_und_evt(tx_und_evt),
    .tx_empty(tx_empty), .tx_full(tx_full), .dma_req(dma_req),
    .dma_ack(dma_ack), .irq(irq), .aud_rst_n(aud_rst_n)
  );

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    v[0] = m_run; v[1] = m_ier; v[2] = m_iet; v[3] = m_act; v[4] = m_pause;
    v[8] = m_rxf; v[9] = m_txf; v[12] = tx_empty; v[13] = tx_full;
    return v;
  endfunction

  function automatic logic exp_irq();
    return (m_rxf & m_ier) | (m_txf & m_iet);
  endfunction

  function automatic logic exp_req();
    return m_busy & m_act;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string rtag, input string qtag);
    chk(rtag, "reg_rdata", reg_rdata, exp_rd());
    chk("R6", "irq", {31'b0, irq}, {31'b0, exp_irq()});
    chk(qtag, "dma_req", {31'b0, dma_req}, {31'b0, exp_req()});
    chk("R2", "aud_rst_n", {31'b0, aud_rst_n}, {31'b0, m_run});
  endtask

  // drive one cycle of inputs, advance model across the next rising edge
  task automatic step(input logic wr, input logic [31:0] wd, input logic rx, input logic tx,
                      input logic emp, input logic full, input logic ack);
    logic nb;
    reg_wr = wr; reg_wdata = wd; rx_ovf_evt = rx; tx_und_evt = tx;
    tx_empty = emp; tx_full = full; dma_ack = ack;
    nb = m_act & (m_busy ? !ack : (!m_pause & !full));
    m_rxf = rx | (m_rxf & !(wr & wd[8]));
    m_txf = tx | (m_txf & !(wr & wd[9]));
    if (wr) begin
      m_run = wd[0]; m_ier = wd[1]; m_iet = wd[2]; m_act = wd[3]; m_pause = wd[4];
    end
    m_busy = nb;
    @(negedge clk);
  endtask

  task automatic idle(input logic full);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, full, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    {m_run, m_ier, m_iet, m_act, m_pause, m_rxf, m_txf, m_busy} = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; rx_ovf_evt = 1'b0;
    tx_und_evt = 1'b0; tx_empty = 1'b0; tx_full = 1'b0; dma_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1", "R1");

    // R8: reserved bits read 0 after writing all ones (flags W1C no-op while clear)
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R8", "R9");
    step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R8", "R11");

    // R2: release software reset
    step(1'b1, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R2", "R9");

    // R3: set, write 0 keeps, write 1 clears
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R3", "R9");
    step(1'b1, 32'h7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R3", "R9");
    step(1'b1, 32'h107, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R3", "R9");

    // R4: same for underrun
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    compare("R4", "R9");
    step(1'b1, 32'h207, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R4", "R9");

    // R5: event and clear collide
    step(1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h307, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    compare("R5", "R9");
    chk("R5", "rx flag", {31'b0, reg_rdata[8]}, 32'h1);
    step(1'b1, 32'h301, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R6", "R9");

    // R7: status mirrors, writes ignored
    step(1'b1, 32'h0000_3001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    compare("R7", "R9");
    step(1'b1, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R7", "R9");

    // R12: active but FIFO full
    step(1'b1, 32'h9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(1'b1); idle(1'b1);
    compare("R12", "R12");
    chk("R12", "dma_req", {31'b0, dma_req}, 32'h0);

    // R9/R10: request rises, pause during flight, hold to ack, no restart
    idle(1'b0); idle(1'b0);
    compare("R9", "R9");
    chk("R9", "dma_req", {31'b0, dma_req}, 32'h1);
    step(1'b1, 32'h19, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(1'b0);
    compare("R10", "R10");
    chk("R10", "dma_req held", {31'b0, dma_req}, 32'h1);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(1'b0); idle(1'b0);
    compare("R10", "R10");
    chk("R10", "dma_req after ack", {31'b0, dma_req}, 32'h0);

    // R11: unpause, request, then kill without ack
    step(1'b1, 32'h9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(1'b0);
    chk("R9", "dma_req", {31'b0, dma_req}, 32'h1);
    step(1'b1, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compare("R11", "R11");
    chk("R11", "dma_req", {31'b0, dma_req}, 32'h0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [31:0] wd;
      wr = ($urandom % 8) == 0;
      wd = $urandom;
      step(wr, wd, ($urandom % 12) == 0, ($urandom % 12) == 0,
           $urandom % 2, ($urandom % 4) == 0, ($urandom % 3) == 0);
      compare("R3", "R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule